// File: doc/BRIEF.md
# E3 Receive Loss-of-Signal and All-Ones Alarm Monitor

This block sits behind the line interface of an E3 receiver. It takes the recovered serial stream one bit at a time. A qualifier marks each accepted bit, and a frame-start strobe from the upstream framer marks the first bit of every frame. From that stream it tracks two line alarms. The first is loss of signal: a long absence of ones on the line. The second is the alarm indication signal: frames that are almost entirely ones.

While loss of signal is active, the block drives a dedicated output pin high. Both alarm states can be read through a small register read port, together with two change flags. A change flag is raised each time an alarm enters or leaves its active state, and it is cleared when software reads the flag register. A single interrupt line combines the change flags, each gated by its own enable pin.

The bit input carries no back-pressure: `rx_vld` is the valid of a stream whose ready is permanently asserted. Every cycle with `rx_vld` high consumes exactly one bit, and cycles with `rx_vld` low are ignored. The read port is combinational. `rd_data` reflects the addressed register in the same cycle that `rd_en` is high, and any clear-on-read takes effect at the closing clock edge.

Top module: `e3_alarm_mon`

## Requirements
- R1: After reset, `los_out` is 1, the loss-of-signal status bit is 1, the all-ones status bit is 0, both change flags are 0 and `irq` is 0.
- R2: Loss of signal is declared on the accepted bit that completes 32 consecutive zero bits; `los_out` goes high after that clock edge. Cycles with `rx_vld` low neither advance nor break any run.
- R3: Loss of signal is cleared on the 32nd accepted bit after the most recent run of 4 or more consecutive zeros. Any new run of 4 zeros restarts this window; a run of 3 zeros does not.
- R4: A frame starts at an accepted bit with `rx_frm_start` high, and that bit belongs to the new frame. At each frame start, the frame just ended is judged (except at the first frame start after reset, which only begins counting). The all-ones alarm is declared when 2 consecutive judged frames each held 7 or fewer zeros. It is cleared when a judged frame held 8 or more zeros.
- R5: With `rd_en` high, address 0x11 returns bit 4 = loss-of-signal state and bit 3 = all-ones state, with all other bits 0. Address 0x14 returns the flag register. Any other address, or `rd_en` low, returns 0x00.
- R6: In the flag register, bit 1 is the loss-of-signal change flag and bit 0 is the all-ones change flag; bits 7 to 2 read 0. A flag becomes 1 one clock after its alarm state changes in either direction.
- R7: A read of address 0x14 returns the flags as they stood before the edge, and clears them at that edge. If a change event reaches a flag at that same edge, that flag stays 1.
- R8: `irq` is 1 exactly when (bit 1 and `irq_en_los`) or (bit 0 and `irq_en_ais`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Stream valid; one bit accepted per high cycle |
| rx_bit | input | 1 | Received line bit |
| rx_frm_start | input | 1 | Marks the accepted bit as the first of a frame |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| irq_en_los | input | 1 | Enable for the loss-of-signal change flag on `irq` |
| irq_en_ais | input | 1 | Enable for the all-ones change flag on `irq` |
| rd_data | output | 8 | Register read data |
| los_out | output | 1 | Loss-of-signal pin, high while the alarm is active |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-zero declare run, a 4-zero break run, a 32-bit clearing window, a limit of 7 zeros per frame and 2 frames to declare. With these values, every counter reaches saturation within a few hundred bits. To keep runs short, the bench marks frames every 128 bits rather than every 1536. This still drives the per-frame zero count across its saturation point of 8, and it reaches the borderline frames of 7 and 8 zeros directly.

// File: rtl/e3am_pkg.sv
package e3am_pkg;
  localparam logic [7:0] ADDR_STATUS = 8'h11;
  localparam logic [7:0] ADDR_FLAGS  = 8'h14;
  localparam int         ST_LOS_POS  = 4;
  localparam int         ST_AIS_POS  = 3;
  localparam int         ALM_AIS     = 0;
  localparam int         ALM_LOS     = 1;
  localparam int         NUM_ALM     = 2;

  typedef struct packed {
    logic los;
    logic ais;
  } alarm_t;
endpackage

// File: rtl/e3am_los_det.sv
module e3am_los_det #(
  parameter int SET_RUN   = 32,
  parameter int BREAK_RUN = 4,
  parameter int CLR_WIN   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_vld,
  input  logic rx_bit,
  output logic los,
  output logic los_chg
);
  localparam int RW = $clog2(SET_RUN + 1);
  localparam int WW = $clog2(CLR_WIN + 1);

  logic [RW-1:0] zrun_q, zrun_nx;
  logic [WW-1:0] win_q, win_nx;
  logic          set_c, clr_c;

  always_comb begin
    if (rx_bit)                        zrun_nx = '0;
    else if (zrun_q == RW'(SET_RUN))   zrun_nx = zrun_q;
    else                               zrun_nx = zrun_q + RW'(1);
    if (zrun_nx >= RW'(BREAK_RUN))     win_nx = '0;
    else if (win_q == WW'(CLR_WIN))    win_nx = win_q;
    else                               win_nx = win_q + WW'(1);
    set_c = rx_vld && !los && (zrun_nx == RW'(SET_RUN));
    clr_c = rx_vld && los && (win_nx == WW'(CLR_WIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun_q  <= '0;
      win_q   <= '0;
      los     <= 1'b1;
      los_chg <= 1'b0;
    end else begin
      if (rx_vld) begin
        zrun_q <= zrun_nx;
        win_q  <= win_nx;
      end
      if (set_c)      los <= 1'b1;
      else if (clr_c) los <= 1'b0;
      los_chg <= set_c | clr_c;
    end
  end

  AST_LOS_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(rx_vld && !rx_bit)); // R2
  AST_LOS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |=> $stable(los)); // R2
  AST_LOS_CHG_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(los) || $fell(los)) |-> los_chg); // R6
endmodule

// File: rtl/e3am_ais_det.sv
module e3am_ais_det #(
  parameter int MAX_ZEROS = 7,
  parameter int FRAMES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_vld,
  input  logic rx_bit,
  input  logic rx_frm_start,
  output logic ais,
  output logic ais_chg
);
  localparam int CW  = $clog2(MAX_ZEROS + 2);
  localparam int FW  = $clog2(FRAMES + 1);
  localparam int SAT = MAX_ZEROS + 1;

  logic [CW-1:0] zcnt_q;
  logic [FW-1:0] lowc_q, lowc_nx;
  logic          have_q, judge, low, set_c, clr_c;

  always_comb begin
    judge = rx_vld && rx_frm_start && have_q;
    low   = (zcnt_q <= CW'(MAX_ZEROS));
    if (!low)                        lowc_nx = '0;
    else if (lowc_q == FW'(FRAMES))  lowc_nx = lowc_q;
    else                             lowc_nx = lowc_q + FW'(1);
    set_c = judge && low && !ais && (lowc_nx == FW'(FRAMES));
    clr_c = judge && !low && ais;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q  <= '0;
      lowc_q  <= '0;
      have_q  <= 1'b0;
      ais     <= 1'b0;
      ais_chg <= 1'b0;
    end else begin
      if (rx_vld) begin
        if (rx_frm_start) begin
          have_q <= 1'b1;
          zcnt_q <= rx_bit ? CW'(0) : CW'(1);
        end else if (!rx_bit && zcnt_q != CW'(SAT)) begin
          zcnt_q <= zcnt_q + CW'(1);
        end
      end
      if (judge) lowc_q <= lowc_nx;
      if (set_c)      ais <= 1'b1;
      else if (clr_c) ais <= 1'b0;
      ais_chg <= set_c | clr_c;
    end
  end

  AST_AIS_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_vld && rx_frm_start) |=> $stable(ais)); // R4
  AST_AIS_CHG_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ais) || $fell(ais)) |-> ais_chg); // R6
endmodule

// File: rtl/e3am_regs.sv
module e3am_regs
  import e3am_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  alarm_t               state,
  input  logic [NUM_ALM-1:0]   chg,
  input  logic [NUM_ALM-1:0]   en,
  input  logic                 rd_en,
  input  logic [7:0]           rd_addr,
  output logic [7:0]           rd_data,
  output logic                 irq
);
  logic               rd_flags;
  logic [NUM_ALM-1:0] flag;

  assign rd_flags = rd_en && (rd_addr == ADDR_FLAGS);

  for (genvar g = 0; g < NUM_ALM; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= chg[g] | (flag_q & ~rd_flags);
    end
    assign flag[g] = flag_q;
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (rd_addr)
        ADDR_STATUS: begin
          rd_data[ST_LOS_POS] = state.los;
          rd_data[ST_AIS_POS] = state.ais;
        end
        ADDR_FLAGS: rd_data[NUM_ALM-1:0] = flag;
        default: rd_data = 8'h00;
      endcase
    end
  end

  assign irq = |(flag & en);

  AST_LOS_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    chg[ALM_LOS] |=> flag[ALM_LOS]); // R6
  AST_AIS_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    chg[ALM_AIS] |=> flag[ALM_AIS]); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && chg == '0) |=> (flag == '0)); // R7
endmodule

// File: rtl/e3_alarm_mon.sv
module e3_alarm_mon
  import e3am_pkg::*;
#(
  parameter int LOS_SET_RUN   = 32,
  parameter int LOS_BREAK_RUN = 4,
  parameter int LOS_CLR_WIN   = 32,
  parameter int AIS_MAX_ZEROS = 7,
  parameter int AIS_FRAMES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_vld,
  input  logic       rx_bit,
  input  logic       rx_frm_start,
  input  logic       rd_en,
  input  logic [7:0] rd_addr,
  input  logic       irq_en_los,
  input  logic       irq_en_ais,
  output logic [7:0] rd_data,
  output logic       los_out,
  output logic       irq
);
  alarm_t             st;
  logic [NUM_ALM-1:0] chg, en;

  e3am_los_det #(
    .SET_RUN  (LOS_SET_RUN),
    .BREAK_RUN(LOS_BREAK_RUN),
    .CLR_WIN  (LOS_CLR_WIN)
  ) u_los (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_bit(rx_bit),
    .los(st.los), .los_chg(chg[ALM_LOS])
  );

  e3am_ais_det #(
    .MAX_ZEROS(AIS_MAX_ZEROS),
    .FRAMES   (AIS_FRAMES)
  ) u_ais (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_bit(rx_bit),
    .rx_frm_start(rx_frm_start), .ais(st.ais), .ais_chg(chg[ALM_AIS])
  );

  assign en[ALM_LOS] = irq_en_los;
  assign en[ALM_AIS] = irq_en_ais;

  e3am_regs u_regs (
    .clk(clk), .rst_n(rst_n), .state(st), .chg(chg), .en(en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  assign los_out = st.los;

  AST_PIN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> los_out); // R1
endmodule

// File: tb/e3_alarm_mon_tb.sv
module e3_alarm_mon_tb_top;
  localparam int FRM = 128;

  logic clk = 1'b0;
  logic rst_n, rx_vld, rx_bit, rx_frm_start, rd_en, en_los, en_ais;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic los_out, irq;

  int n_chk = 0;
  int n_err = 0;

  int m_zrun, m_win, m_zc, m_lowc;
  bit m_have, m_los, m_ais;
  bit [1:0] m_int, m_pend;

  always #10 clk = ~clk;

  e3_alarm_mon dut_i (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_bit(rx_bit),
    .rx_frm_start(rx_frm_start), .rd_en(rd_en), .rd_addr(rd_addr),
    .irq_en_los(en_los), .irq_en_ais(en_ais), .rd_data(rd_data),
    .los_out(los_out), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(int v, int lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic void model_bit(bit b, bit fs);
    bit old_los = m_los;
    bit old_ais = m_ais;
    m_zrun = b ? 0 : sat(m_zrun + 1, 32);
    m_win  = (m_zrun >= 4) ? 0 : sat(m_win + 1, 32);
    if (!m_los && m_zrun == 32)    m_los = 1'b1;
    else if (m_los && m_win == 32) m_los = 1'b0;
    if (fs) begin
      if (m_have) begin
        if (m_zc <= 7) begin
          m_lowc = sat(m_lowc + 1, 2);
          if (m_lowc == 2) m_ais = 1'b1;
        end else begin
          m_lowc = 0;
          m_ais  = 1'b0;
        end
      end
      m_have = 1'b1;
      m_zc   = b ? 0 : 1;
    end else begin
      m_zc = sat(m_zc + (b ? 0 : 1), 8);
    end
    m_pend = {m_los != old_los, m_ais != old_ais};
  endfunction

  function automatic bit [7:0] exp_reg(bit [7:0] a);
    if (a == 8'h11) return {3'b000, m_los, m_ais, 3'b000};
    if (a == 8'h14) return {6'b0, m_int};
    return 8'h00;
  endfunction

  task automatic tick(bit acc, bit b, bit fs, bit rdclr);
    @(posedge clk);
    m_int  = (m_int & ~{2{rdclr}}) | m_pend;
    m_pend = 2'b00;
    if (acc) model_bit(b, fs);
    @(negedge clk);
  endtask

  task automatic send_bit(bit b, bit fs);
    rx_vld = 1'b1; rx_bit = b; rx_frm_start = fs;
    tick(1'b1, b, fs, 1'b0);
    rx_vld = 1'b0; rx_frm_start = 1'b0;
    check("R2/R3 los_out", los_out, m_los);
  endtask

  task automatic send_run(bit b, int n);
    for (int i = 0; i < n; i++) send_bit(b, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      rx_vld = 1'b0; rx_bit = 1'b0; rx_frm_start = $urandom_range(0, 1);
      tick(1'b0, 1'b0, 1'b0, 1'b0);
    end
    rx_frm_start = 1'b0;
  endtask

  task automatic read_reg(bit [7:0] a, string req);
    rd_en = 1'b1; rd_addr = a;
    #1;
    check(req, rd_data, exp_reg(a));
    check("R8 irq", irq, |(m_int & {en_los, en_ais}));
    tick(1'b0, 1'b0, 1'b0, a == 8'h14);
    rd_en = 1'b0;
  endtask

  task automatic send_frame(int nz);
    for (int i = 0; i < FRM; i++)
      send_bit(!((i % 2 == 1) && (i / 2 < nz)), i == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; rx_vld = 1'b0; rx_bit = 1'b0; rx_frm_start = 1'b0;
    rd_en = 1'b0; rd_addr = 8'h00; en_los = 1'b0; en_ais = 1'b0;
    m_zrun = 0; m_win = 0; m_zc = 0; m_lowc = 0;
    m_have = 0; m_los = 1; m_ais = 0; m_int = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 los_out", los_out, 1);
    check("R1 irq", irq, 0);
    read_reg(8'h11, "R1 status");
    read_reg(8'h14, "R1 flags");
    read_reg(8'h33, "R5 unmapped");

    // R3 clear after 32 ones
    send_run(1'b1, 31);
    check("R3 still active at 31", los_out, 1);
    send_bit(1'b1, 1'b0);
    check("R3 cleared at 32", los_out, 0);
    idle(1);
    read_reg(8'h14, "R6 los flag");
    read_reg(8'h14, "R7 flag cleared");

    // R2 idle cycles ignored, 31 zeros not enough
    send_run(1'b0, 20);
    idle(40);
    send_run(1'b0, 11);
    check("R2 31 zeros", los_out, 0);
    send_bit(1'b1, 1'b0);
    send_run(1'b0, 31);
    check("R2 no LOS at 31", los_out, 0);
    send_bit(1'b0, 1'b0);
    check("R2 LOS at 32", los_out, 1);
    read_reg(8'h14, "R7 read races event");
    read_reg(8'h14, "R7 event kept");

    // R3 window restart on four zeros, not on three
    send_run(1'b1, 20); send_run(1'b0, 4); send_run(1'b1, 31);
    check("R3 window restarted", los_out, 1);
    send_bit(1'b1, 1'b0);
    check("R3 cleared after restart", los_out, 0);
    send_run(1'b0, 32);
    send_run(1'b1, 20); send_run(1'b0, 3); send_run(1'b1, 9);
    check("R3 three zeros do not restart", los_out, 0);

    // R4 AIS directed
    en_los = 1'b1;
    read_reg(8'h14, "R8 irq with los enable");
    send_frame(7); send_frame(7); send_frame(7);
    read_reg(8'h11, "R4 AIS declared");
    en_ais = 1'b1;
    read_reg(8'h14, "R6 ais flag");
    send_frame(8); send_frame(7);
    read_reg(8'h11, "R4 AIS cleared by 8");
    send_frame(7); send_frame(8); send_frame(7);
    read_reg(8'h11, "R4 isolated low frame");
    read_reg(8'h14, "R6 R7 flags");

    // random phase
    for (int f = 0; f < 60; f++) begin
      int p;
      case ($urandom_range(0, 4))
        0: p = 0; 1: p = 3; 2: p = 6; 3: p = 50; default: p = 97;
      endcase
      for (int i = 0; i < FRM; i++) begin
        send_bit(($urandom % 100) >= p, i == 0);
        if ($urandom_range(0, 15) == 0) idle(1);
      end
      en_los = $urandom_range(0, 1);
      en_ais = $urandom_range(0, 1);
      read_reg(8'h11, "R4 R5 status random");
      read_reg(8'h14, "R6 R7 flags random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule